// File: doc/BRIEF.md
# Redistributor Frame Decoder

This block sits behind a memory-mapped access port of an interrupt controller. It takes one access (address, size, write flag, write data) and works out where the access lands. The access can land in the distributor window, in one CPU's redistributor frame, or nowhere. Each redistributor frame is 0x20000 bytes and is split into two 64 KiB pages. The lower page is a control page holding identification and type information. The upper page holds the state arrays for the 32 private interrupts (software-generated plus per-processor).

The frame number taken from the address selects the CPU whose state is read or written. The CPU that issued the access plays no part, so any processor can inspect or change another processor's private interrupts. The number of online CPUs sets how far the redistributor region reaches. An affinity table supplies the three affinity bytes that each CPU reports.

Reads are combinational in the cycle the request is presented. Writes to the private-interrupt arrays take effect at the next rising clock edge.

Top module: `redistFrameDecoder`

## Requirements
- R1: An access lands in the distributor window (regionSel = 1) when it starts at or above distBase and its last byte is below distBase + 0x10000. The access length is 1 << reqSize bytes. This check wins over the redistributor check.
- R2: Otherwise, an access whose bytes all lie in [redistBase, redistBase + onlineCpus × 0x20000) lands in the redistributor region (regionSel = 2). In that case frameIdx = (reqAddr − redistBase) >> 17 and sgiPage is bit 16 of that offset. Any other access, including one that runs past the end of the region, and any cycle with reqValid low, gives regionSel = 0.
- R3: The control-page word at 0x0008 reads as frameIdx << 8, with bit 4 set only when frameIdx = onlineCpus − 1. Writes to it are ignored.
- R4: The control-page word at 0x000C reads as {8'h00, affinity entry}. Entry i of affTable is affTable[24i+23:24i], with the lowest affinity level in bits 7:0 and the highest in bits 23:16.
- R5: On the control page, 0x0000 and 0x0014 read zero. Inside 0xFFD0–0xFFFC, only 0xFFE8 returns 0x3B and the rest read zero. Every other control-page word also reads zero.
- R6: The upper-page word at 0x0080 reads 0xFFFFFFFF. The words 0x0300, 0x0380, 0x0D00 and 0x0E00 read zero. Writes to all five are ignored.
- R7: Writing to upper-page word 0x0100 sets the enable bits that are 1 in reqWdata. Writing to 0x0180 clears them. Zero bits in reqWdata leave enables unchanged. Both words read the current 32-bit enable map.
- R8: Pending state behaves the same way: 0x0200 sets bits, 0x0280 clears bits, and both read the pending map.
- R9: Upper-page words 0x0400–0x041C hold eight plain read/write 32-bit priority words per CPU.
- R10: Upper-page words 0x0C00 and 0x0C04 hold two plain read/write 32-bit configuration words per CPU.
- R11: Private state is held separately for each CPU. A write changes only the state of the CPU selected by frameIdx.
- R12: After reset, every enable, pending, priority and configuration bit of every CPU reads zero.
- R13: rdData is zero whenever regionSel is not 2. Writes that land in the distributor window or nowhere change no private state.
- R14: Register selection uses address bits 15:2 of the in-frame offset. The low two bits and reqSize affect only the range check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | log2 of the access length in bytes |
| reqWdata | input | 32 | Write data |
| distBase | input | ADDR_W | Distributor window base |
| redistBase | input | ADDR_W | Base of the redistributor frame 0 |
| onlineCpus | input | CNT_W | Number of online CPUs (clamped to MAX_CPUS) |
| affTable | input | 24·MAX_CPUS | Packed per-CPU affinity bytes |
| regionSel | output | 2 | 0 none, 1 distributor, 2 redistributor |
| frameIdx | output | CPU_W | Addressed CPU frame |
| sgiPage | output | 1 | 1 = upper (private-interrupt) page |
| rdData | output | 32 | Read data |

## Verification
The bench sweeps addresses across both region edges with 4- and 8-byte accesses for every online count. This catches off-by-one limits, a range check that ignores the access length, and a wrong precedence between overlapping windows. It computes the LAST flag and the affinity word for every frame under every online count, so a flag tied to the wrong CPU or a misordered affinity field would show up. It writes distinct patterns into each CPU's arrays and reads them back from every frame. This exposes state indexed by the wrong CPU, set and clear strobes that are swapped, and writes leaking through read-only or out-of-region addresses.

// File: rtl/rdFramePkg.sv
package rdFramePkg;

  localparam int DATA_W      = 32;
  localparam int AFF_W       = 24;
  localparam int DIST_SPAN   = 32'h0001_0000;
  localparam int FRAME_SHIFT = 17;
  localparam int PAGE_BIT    = 16;
  localparam int PRIO_WORDS  = 8;
  localparam int CFG_WORDS   = 2;

  // word offsets (byte offset >> 2) inside a 64 KiB page
  localparam logic [13:0] W_TYPE_LO  = 14'h0002;
  localparam logic [13:0] W_TYPE_HI  = 14'h0003;
  localparam logic [13:0] W_IDENT    = 14'h3FFA;
  localparam logic [13:0] W_GROUP    = 14'h0020;
  localparam logic [13:0] W_SET_EN   = 14'h0040;
  localparam logic [13:0] W_CLR_EN   = 14'h0060;
  localparam logic [13:0] W_SET_PEND = 14'h0080;
  localparam logic [13:0] W_CLR_PEND = 14'h00A0;
  localparam logic [13:0] W_PRIO     = 14'h0100;
  localparam logic [13:0] W_CFG      = 14'h0300;

  typedef enum logic [1:0] {
    REGION_NONE   = 2'd0,
    REGION_DIST   = 2'd1,
    REGION_REDIST = 2'd2
  } regionE;

  typedef enum logic [3:0] {
    RD_ZERO, RD_ONES, RD_TYPE_LO, RD_TYPE_HI, RD_IDENT,
    RD_ENABLE, RD_PENDING, RD_PRIO, RD_CFG
  } rdSelE;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setPend;
    logic clrPend;
    logic wrPrio;
    logic wrCfg;
  } wrStrobeT;

endpackage

// File: rtl/rdAddrDecode.sv
module rdAddrDecode
  import rdFramePkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_CPUS = 4,
  localparam int CPU_W   = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int CNT_W   = $clog2(MAX_CPUS + 1)
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] distBase,
  input  logic [ADDR_W-1:0] redistBase,
  input  logic [CNT_W-1:0]  onlineCpus,
  output regionE            regionSel,
  output logic [CPU_W-1:0]  frameIdx,
  output logic              sgiPage,
  output rdSelE             rdSel,
  output logic [2:0]        wordSel,
  output wrStrobeT          strb
);

  localparam int LIM_W = (ADDR_W > CNT_W + FRAME_SHIFT) ? ADDR_W : CNT_W + FRAME_SHIFT;
  localparam int EXT_W = LIM_W + 2;

  logic [EXT_W-1:0] accBytes, distOff, rdOff, redistLimit;
  logic [CNT_W-1:0] onlineEff;
  logic             distHit, redistHit, isWr;
  logic [13:0]      wordOff;

  always_comb begin
    accBytes    = EXT_W'(1) << reqSize;
    distOff     = EXT_W'(reqAddr) - EXT_W'(distBase);
    rdOff       = EXT_W'(reqAddr) - EXT_W'(redistBase);
    onlineEff   = (onlineCpus > CNT_W'(MAX_CPUS)) ? CNT_W'(MAX_CPUS) : onlineCpus;
    redistLimit = EXT_W'(onlineEff) << FRAME_SHIFT;
    distHit     = (reqAddr >= distBase) && (distOff + accBytes <= EXT_W'(DIST_SPAN));
    redistHit   = (reqAddr >= redistBase) && (rdOff + accBytes <= redistLimit);
  end

  always_comb begin
    if (!reqValid)      regionSel = REGION_NONE;
    else if (distHit)   regionSel = REGION_DIST;
    else if (redistHit) regionSel = REGION_REDIST;
    else                regionSel = REGION_NONE;
  end

  assign frameIdx = rdOff[FRAME_SHIFT +: CPU_W];
  assign sgiPage  = rdOff[PAGE_BIT];
  assign wordOff  = rdOff[15:2];
  assign isWr     = (regionSel == REGION_REDIST) && reqWrite;

  // register select and write strobes for the addressed frame
  always_comb begin
    rdSel   = RD_ZERO;
    wordSel = '0;
    strb    = '0;
    if (regionSel == REGION_REDIST) begin
      if (!sgiPage) begin
        if (wordOff == W_TYPE_LO)      rdSel = RD_TYPE_LO;
        else if (wordOff == W_TYPE_HI) rdSel = RD_TYPE_HI;
        else if (wordOff == W_IDENT)   rdSel = RD_IDENT;
      end else begin
        if (wordOff == W_GROUP) begin
          rdSel = RD_ONES;
        end else if (wordOff == W_SET_EN || wordOff == W_CLR_EN) begin
          rdSel        = RD_ENABLE;
          strb.setEn   = isWr && (wordOff == W_SET_EN);
          strb.clrEn   = isWr && (wordOff == W_CLR_EN);
        end else if (wordOff == W_SET_PEND || wordOff == W_CLR_PEND) begin
          rdSel        = RD_PENDING;
          strb.setPend = isWr && (wordOff == W_SET_PEND);
          strb.clrPend = isWr && (wordOff == W_CLR_PEND);
        end else if (wordOff >= W_PRIO && wordOff < W_PRIO + 14'(PRIO_WORDS)) begin
          rdSel        = RD_PRIO;
          wordSel      = wordOff[2:0];
          strb.wrPrio  = isWr;
        end else if (wordOff >= W_CFG && wordOff < W_CFG + 14'(CFG_WORDS)) begin
          rdSel        = RD_CFG;
          wordSel      = {2'b00, wordOff[0]};
          strb.wrCfg   = isWr;
        end
      end
    end
  end

endmodule

// File: rtl/rdPrivDatapath.sv
module rdPrivDatapath
  import rdFramePkg::*;
#(
  parameter int MAX_CPUS = 4,
  localparam int CPU_W   = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int CNT_W   = $clog2(MAX_CPUS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobeT                  strb,
  input  logic [CPU_W-1:0]          frameIdx,
  input  logic [2:0]                wordSel,
  input  rdSelE                     rdSel,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [CNT_W-1:0]          onlineCpus,
  input  logic [AFF_W*MAX_CPUS-1:0] affTable,
  output logic [DATA_W-1:0]         rdData
);

  logic [DATA_W-1:0]                 enArr   [MAX_CPUS];
  logic [DATA_W-1:0]                 pendArr [MAX_CPUS];
  logic [PRIO_WORDS-1:0][DATA_W-1:0] prioArr [MAX_CPUS];
  logic [CFG_WORDS-1:0][DATA_W-1:0]  cfgArr  [MAX_CPUS];
  logic [AFF_W-1:0]                  affArr  [MAX_CPUS];

  for (genvar c = 0; c < MAX_CPUS; c++) begin : gCpu
    logic                              sel;
    logic [DATA_W-1:0]                 enQ, pendQ;
    logic [PRIO_WORDS-1:0][DATA_W-1:0] prioQ;
    logic [CFG_WORDS-1:0][DATA_W-1:0]  cfgQ;

    assign sel = (frameIdx == CPU_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ   <= '0;
        pendQ <= '0;
        prioQ <= '0;
        cfgQ  <= '0;
      end else if (sel) begin
        if (strb.setEn)   enQ   <= enQ | wdata;
        if (strb.clrEn)   enQ   <= enQ & ~wdata;
        if (strb.setPend) pendQ <= pendQ | wdata;
        if (strb.clrPend) pendQ <= pendQ & ~wdata;
        if (strb.wrPrio)  prioQ[wordSel] <= wdata;
        if (strb.wrCfg)   cfgQ[wordSel[0]] <= wdata;
      end
    end

    assign enArr[c]   = enQ;
    assign pendArr[c] = pendQ;
    assign prioArr[c] = prioQ;
    assign cfgArr[c]  = cfgQ;
    assign affArr[c]  = affTable[c*AFF_W +: AFF_W];
  end

  logic [CNT_W-1:0] onlineEff;
  logic             lastFrame;

  assign onlineEff = (onlineCpus > CNT_W'(MAX_CPUS)) ? CNT_W'(MAX_CPUS) : onlineCpus;
  assign lastFrame = (CNT_W'(frameIdx) + CNT_W'(1)) == onlineEff;

  always_comb begin
    unique case (rdSel)
      RD_ONES:    rdData = '1;
      RD_TYPE_LO: rdData = (DATA_W'(frameIdx) << 8) | (lastFrame ? DATA_W'(32'h10) : '0);
      RD_TYPE_HI: rdData = DATA_W'(affArr[frameIdx]);
      RD_IDENT:   rdData = DATA_W'(32'h3B);
      RD_ENABLE:  rdData = enArr[frameIdx];
      RD_PENDING: rdData = pendArr[frameIdx];
      RD_PRIO:    rdData = prioArr[frameIdx][wordSel];
      RD_CFG:     rdData = cfgArr[frameIdx][wordSel[0]];
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/redistFrameDecoder.sv
module redistFrameDecoder
  import rdFramePkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_CPUS = 4,
  localparam int CPU_W   = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int CNT_W   = $clog2(MAX_CPUS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqSize,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [ADDR_W-1:0]         distBase,
  input  logic [ADDR_W-1:0]         redistBase,
  input  logic [CNT_W-1:0]          onlineCpus,
  input  logic [AFF_W*MAX_CPUS-1:0] affTable,
  output logic [1:0]                regionSel,
  output logic [CPU_W-1:0]          frameIdx,
  output logic                      sgiPage,
  output logic [DATA_W-1:0]         rdData
);

  regionE   regionInt;
  rdSelE    rdSel;
  logic [2:0] wordSel;
  wrStrobeT strb;

  rdAddrDecode #(.ADDR_W(ADDR_W), .MAX_CPUS(MAX_CPUS)) u_decode (
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .distBase  (distBase),
    .redistBase(redistBase),
    .onlineCpus(onlineCpus),
    .regionSel (regionInt),
    .frameIdx  (frameIdx),
    .sgiPage   (sgiPage),
    .rdSel     (rdSel),
    .wordSel   (wordSel),
    .strb      (strb)
  );

  rdPrivDatapath #(.MAX_CPUS(MAX_CPUS)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .frameIdx  (frameIdx),
    .wordSel   (wordSel),
    .rdSel     (rdSel),
    .wdata     (reqWdata),
    .onlineCpus(onlineCpus),
    .affTable  (affTable),
    .rdData    (rdData)
  );

  assign regionSel = regionInt;

endmodule

// File: rtl/rdFrameChecker.sv
module rdFrameChecker #(
  parameter int ADDR_W   = 32,
  parameter int MAX_CPUS = 4,
  localparam int CPU_W   = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int CNT_W   = $clog2(MAX_CPUS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       reqWdata,
  input logic [ADDR_W-1:0] distBase,
  input logic [ADDR_W-1:0] redistBase,
  input logic [CNT_W-1:0]  onlineCpus,
  input logic [1:0]        regionSel,
  input logic [CPU_W-1:0]  frameIdx,
  input logic              sgiPage,
  input logic [31:0]       rdData
);

  logic             pastOk;
  logic [13:0]      chkWord;
  logic [CNT_W-1:0] onlineEff;
  logic             inRedist, wrSetEn, wrClrPend;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;

  assign chkWord   = 14'((reqAddr - redistBase) >> 2);
  assign onlineEff = (onlineCpus > CNT_W'(MAX_CPUS)) ? CNT_W'(MAX_CPUS) : onlineCpus;
  assign inRedist  = reqValid && (regionSel == 2'd2);
  assign wrSetEn   = inRedist && reqWrite && sgiPage && chkWord == 14'h0040;
  assign wrClrPend = inRedist && reqWrite && sgiPage && chkWord == 14'h00A0;

  // R1: an 8-byte-safe offset inside the distributor window always claims it
  a_r1_dist_first: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= distBase && (reqAddr - distBase) <= ADDR_W'(32'hFFF8))
      |-> regionSel == 2'd1);

  a_r2_frame_online: assert property (@(posedge clk) disable iff (!rstN)
    inRedist |-> (CNT_W'(frameIdx) < onlineEff));

  a_r3_last_flag: assert property (@(posedge clk) disable iff (!rstN)
    (inRedist && !sgiPage && chkWord == 14'h0002)
      |-> (rdData[4] == ((CNT_W'(frameIdx) + CNT_W'(1)) == onlineEff)
           && rdData[15:8] == 8'(frameIdx)));

  a_r5_ident: assert property (@(posedge clk) disable iff (!rstN)
    (inRedist && !sgiPage && chkWord == 14'h3FFA) |-> rdData == 32'h3B);

  a_r6_group_ones: assert property (@(posedge clk) disable iff (!rstN)
    (inRedist && sgiPage && chkWord == 14'h0020) |-> rdData == 32'hFFFF_FFFF);

  a_r7_set_enable: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && inRedist && !reqWrite && sgiPage && chkWord == 14'h0040
      && $past(wrSetEn) && $past(frameIdx) == frameIdx)
      |-> ((rdData & $past(reqWdata)) == $past(reqWdata)));

  a_r8_clear_pending: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && inRedist && !reqWrite && sgiPage && chkWord == 14'h0080
      && $past(wrClrPend) && $past(frameIdx) == frameIdx)
      |-> ((rdData & $past(reqWdata)) == 32'h0));

  a_r13_no_data_off_region: assert property (@(posedge clk) disable iff (!rstN)
    (regionSel != 2'd2) |-> rdData == 32'h0);

endmodule

bind redistFrameDecoder rdFrameChecker #(.ADDR_W(ADDR_W), .MAX_CPUS(MAX_CPUS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqAddr   (reqAddr),
  .reqWdata  (reqWdata),
  .distBase  (distBase),
  .redistBase(redistBase),
  .onlineCpus(onlineCpus),
  .regionSel (regionSel),
  .frameIdx  (frameIdx),
  .sgiPage   (sgiPage),
  .rdData    (rdData)
);

// File: tb/redistFrameDecoder_tb.sv
module redistFrameDecoder_tb;

  localparam int NCPU = 4;
  localparam logic [31:0] DB = 32'h0800_0000;
  localparam logic [31:0] RB = 32'h080A_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqSize = 2'd2;
  logic [31:0] distBase = DB, redistBase = RB;
  logic [2:0]  onlineCpus = 3'd4;
  logic [24*NCPU-1:0] affTable;
  logic [1:0]  regionSel;
  logic [1:0]  frameIdx;
  logic        sgiPage;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  logic [31:0] mEn [NCPU];
  logic [31:0] mPend [NCPU];
  logic [31:0] mPrio [NCPU][8];
  logic [31:0] mCfg [NCPU][2];

  always #4 clk = ~clk;

  for (genvar i = 0; i < NCPU; i++) begin : gAff
    assign affTable[i*24 +: 24] = 24'h302010 + 24'(i) * 24'h010101;
  end

  redistFrameDecoder #(.ADDR_W(32), .MAX_CPUS(NCPU)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .distBase(distBase), .redistBase(redistBase), .onlineCpus(onlineCpus),
    .affTable(affTable), .regionSel(regionSel), .frameIdx(frameIdx),
    .sgiPage(sgiPage), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqSize = sz; reqWdata = '0;
    #1;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqSize = 2'd2; reqWdata = d;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  function automatic logic [31:0] fa(input int f, input int pg, input int off);
    return RB + 32'(f) * 32'h20000 + 32'(pg) * 32'h10000 + 32'(off);
  endfunction

  function automatic logic [1:0] expRegion(input longint a, input int sz, input int online);
    longint n = longint'(1) << sz;
    if (a >= longint'(DB) && a + n <= longint'(DB) + 64'h10000) return 2'd1;
    if (a >= longint'(RB) && a + n <= longint'(RB) + longint'(online) * 64'h20000) return 2'd2;
    return 2'd0;
  endfunction

  task automatic checkAllState(input string tag);
    for (int f = 0; f < NCPU; f++) begin
      rd(fa(f, 1, 16'h100), 2'd2); chk({tag, " R7 R11 set-en view"}, rdData, mEn[f]);
      rd(fa(f, 1, 16'h180), 2'd2); chk({tag, " R7 R11 clr-en view"}, rdData, mEn[f]);
      rd(fa(f, 1, 16'h200), 2'd2); chk({tag, " R8 R11 set-pend view"}, rdData, mPend[f]);
      rd(fa(f, 1, 16'h280), 2'd2); chk({tag, " R8 R11 clr-pend view"}, rdData, mPend[f]);
      for (int w = 0; w < 8; w++) begin
        rd(fa(f, 1, 16'h400 + 4*w), 2'd2); chk({tag, " R9 R11 prio"}, rdData, mPrio[f][w]);
      end
      for (int w = 0; w < 2; w++) begin
        rd(fa(f, 1, 16'hC00 + 4*w), 2'd2); chk({tag, " R10 R11 cfg"}, rdData, mCfg[f][w]);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int f = 0; f < NCPU; f++) begin
      mEn[f] = '0; mPend[f] = '0;
      for (int w = 0; w < 8; w++) mPrio[f][w] = '0;
      for (int w = 0; w < 2; w++) mCfg[f][w] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: no request, no region; R12 reset state everywhere
    @(negedge clk); #1;
    chk("R2 idle region", 32'(regionSel), 32'd0);
    chk("R13 idle data", rdData, 32'd0);
    checkAllState("R12 reset");

    // R1 R2 R14: address sweep across both windows for every online count and two sizes
    for (int on = 1; on <= NCPU; on++) begin
      onlineCpus = 3'(on);
      for (longint a = longint'(DB) - 64'h8000; a < longint'(RB) + 5 * 64'h20000; a += 64'h4000) begin
        for (int k = 0; k < 2; k++) begin
          longint aa = (k == 0) ? a : a + 64'h3FFC;
          for (int sz = 2; sz <= 3; sz++) begin
            logic [1:0] er = expRegion(aa, sz, on);
            rd(32'(aa), 2'(sz));
            chk("R1 R2 R14 region", 32'(regionSel), 32'(er));
            if (er == 2'd2) begin
              chk("R2 frame", 32'(frameIdx), 32'((aa - longint'(RB)) >> 17));
              chk("R2 page", 32'(sgiPage), 32'(((aa - longint'(RB)) >> 16) & 1));
            end else begin
              chk("R13 data off region", rdData, 32'd0);
            end
          end
        end
      end
      // boundary: last word of the region, then one running past it
      rd(RB + 32'(on) * 32'h20000 - 32'd4, 2'd2);
      chk("R2 last word hit", 32'(regionSel), 32'd2);
      rd(RB + 32'(on) * 32'h20000 - 32'd4, 2'd3);
      chk("R2 straddle miss", 32'(regionSel), 32'd0);
      rd(RB + 32'(on) * 32'h20000 - 32'd1, 2'd0);
      chk("R2 last byte hit", 32'(regionSel), 32'd2);
    end
    rd(DB + 32'hFFFC, 2'd3);
    chk("R1 straddle dist miss", 32'(regionSel), 32'd0);

    // R1: overlapping windows, the distributor wins
    distBase = RB;
    rd(RB + 32'h100, 2'd2);
    chk("R1 overlap precedence", 32'(regionSel), 32'd1);
    distBase = DB;

    // R3 R4: type words for every online count and frame
    for (int on = 1; on <= NCPU; on++) begin
      onlineCpus = 3'(on);
      for (int f = 0; f < on; f++) begin
        rd(fa(f, 0, 16'h0008), 2'd2);
        chk("R3 type low", rdData, (32'(f) << 8) | ((f == on - 1) ? 32'h10 : 32'h0));
        rd(fa(f, 0, 16'h000C), 2'd2);
        chk("R4 type high", rdData, 32'h00302010 + 32'(f) * 32'h010101);
      end
    end
    onlineCpus = 3'd4;
    wr(fa(1, 0, 16'h0008), 32'hFFFF_FFFF);
    rd(fa(1, 0, 16'h0008), 2'd2);
    chk("R3 write ignored", rdData, 32'h0000_0100);
    rd(fa(2, 0, 16'h000E), 2'd1);
    chk("R14 halfword select", rdData, 32'h00322212);

    // R5: control page zero words and identification window
    wr(fa(0, 0, 16'h0000), 32'hFFFF_FFFF);
    rd(fa(0, 0, 16'h0000), 2'd2); chk("R5 control zero", rdData, 32'h0);
    wr(fa(3, 0, 16'h0014), 32'hFFFF_FFFF);
    rd(fa(3, 0, 16'h0014), 2'd2); chk("R5 wake zero", rdData, 32'h0);
    rd(fa(2, 0, 16'h0100), 2'd2); chk("R5 other zero", rdData, 32'h0);
    for (int o = 16'hFFD0; o <= 16'hFFFC; o += 4) begin
      rd(fa(1, 0, o), 2'd2);
      chk("R5 ident window", rdData, (o == 16'hFFE8) ? 32'h3B : 32'h0);
    end

    // R6: fixed upper-page words ignore writes
    wr(fa(2, 1, 16'h0080), 32'h0);
    rd(fa(2, 1, 16'h0080), 2'd2); chk("R6 group ones", rdData, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      int o = (k == 0) ? 16'h300 : (k == 1) ? 16'h380 : (k == 2) ? 16'hD00 : 16'hE00;
      wr(fa(k, 1, o), 32'hFFFF_FFFF);
      rd(fa(k, 1, o), 2'd2);
      chk("R6 zero word", rdData, 32'h0);
    end
    checkAllState("R6 no side effect");

    // R7 R8 R11: set then clear per frame
    for (int f = 0; f < NCPU; f++) begin
      logic [31:0] pe = 32'h0101_0101 << f;
      logic [31:0] pp = 32'hF000_000F ^ (32'h11 << (4 * f));
      wr(fa(f, 1, 16'h100), pe);   mEn[f]   |= pe;
      rd(fa(f, 1, 16'h100), 2'd2); chk("R7 set enable", rdData, mEn[f]);
      wr(fa(f, 1, 16'h200), pp);   mPend[f] |= pp;
      rd(fa(f, 1, 16'h200), 2'd2); chk("R8 set pending", rdData, mPend[f]);
    end
    checkAllState("after set");
    for (int f = 0; f < NCPU; f++) begin
      logic [31:0] ce = 32'h0000_FFFF;
      logic [31:0] cp = 32'hFF00_00F0 >> f;
      wr(fa(f, 1, 16'h180), ce);   mEn[f]   &= ~ce;
      wr(fa(f, 1, 16'h280), cp);   mPend[f] &= ~cp;
      rd(fa(f, 1, 16'h200), 2'd2); chk("R8 clear pending", rdData, mPend[f]);
    end
    wr(fa(1, 1, 16'h100), 32'h0);  // zero bits change nothing
    wr(fa(1, 1, 16'h180), 32'h0);
    checkAllState("after clear");

    // R9 R10 R11: plain storage per frame
    for (int f = 0; f < NCPU; f++) begin
      for (int w = 0; w < 8; w++) begin
        mPrio[f][w] = {8'(f), 8'(w), 16'hA55A ^ 16'(f * 8 + w)};
        wr(fa(f, 1, 16'h400 + 4*w), mPrio[f][w]);
      end
      for (int w = 0; w < 2; w++) begin
        mCfg[f][w] = ~({8'(f), 8'(w), 16'h3C3C});
        wr(fa(f, 1, 16'hC00 + 4*w), mCfg[f][w]);
      end
    end
    checkAllState("after storage");

    // R13: writes through the distributor window or a miss change nothing
    wr(DB + 32'h100, 32'hFFFF_FFFF);
    rd(DB + 32'h100, 2'd2); chk("R13 dist data zero", rdData, 32'h0);
    wr(RB + 32'd4 * 32'h20000 + 32'h10100, 32'hFFFF_FFFF);
    onlineCpus = 3'd2;
    wr(fa(3, 1, 16'h180), 32'hFFFF_FFFF);
    onlineCpus = 3'd4;
    checkAllState("R13 ignored");

    reqValid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule